// File: doc/BRIEF.md
# DMA Bus Bandwidth Throttle

This block sits between the read/write sequencer of a DMA channel and the bus request path. It limits how much bus bandwidth the channel consumes. A two-bit mode field is captured when a channel begins service. The mode selects one of four behaviours:

- free running;
- raising a priority-elevate flag toward the crossbar arbiter;
- a short fixed stall after each write;
- a long fixed stall after each write.

The sequencer reports every completed bus access. With each access it states whether the access was a write and whether it was the final write of the minor loop. The block counts completed accesses from the start of service, so the first two accesses run with no throttling at all. After the final write of a minor loop the sequencer is never held back. The stall output tells the sequencer to wait. The elevate output goes to the arbiter.

Top module: `dma_bw_throttle`

## Requirements
- R1: After reset, `stall_o` and `prio_elev_o` are both low and stay low until a service starts.
- R2: With mode 2'b00 captured, `stall_o` and `prio_elev_o` never go high.
- R3: With mode 2'b01 captured, `stall_o` never goes high. `prio_elev_o` is high while the service is active and at least two accesses have completed since `svc_start`.
- R4: With mode 2'b10 captured, a write that is not marked last and has at least two earlier accesses since `svc_start` raises `stall_o` in the next cycle. `stall_o` then stays high for exactly 4 cycles.
- R5: With mode 2'b11 captured, the same write condition raises `stall_o` for exactly 8 cycles.
- R6: The first two accesses after `svc_start` never cause a stall. `prio_elev_o` stays low until both of them have completed.
- R7: A write with `acc_last` high causes no stall in either stall mode.
- R8: `bw_mode` is sampled only in the cycle `svc_start` is high. Later changes to it do not affect the running service.
- R9: `svc_end` drops `stall_o` and `prio_elev_o` in the next cycle. A new `svc_start` restarts the two-access exemption.
- R10: A completed read (`acc_write` low) never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| svc_start | input | 1 | Pulse: a channel begins service; captures `bw_mode` |
| svc_end | input | 1 | Pulse: the channel's service ends |
| bw_mode | input | 2 | Throttle mode: 00 none, 01 elevate, 10 short stall, 11 long stall |
| acc_done | input | 1 | Pulse: one bus access completed |
| acc_write | input | 1 | The completed access was a write |
| acc_last | input | 1 | The completed write was the final write of the minor loop |
| stall_o | output | 1 | Hold request to the sequencer |
| prio_elev_o | output | 1 | Priority elevation request to the arbiter |

## Verification
A wrong stall counter shows on `stall_o` one cycle after the triggering write. Such a fault gives a stall window that is too short, too long or missing, so the bench counts the high cycles of each stall. A wrong access count or a wrong captured mode shows within two accesses of `svc_start`. The symptoms are early or absent elevation, or a stall where the exemption or the held mode forbids one. The bench compares both outputs every cycle against a model built from the requirements. The bench drives `bw_mode` at random during each service, so a mode that is not held shows up at once.

// File: rtl/dma_bw_throttle.sv
module dma_bw_throttle #(
  parameter int GRACE       = 2,
  parameter int STALL_SHORT = 4,
  parameter int STALL_LONG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_start,
  input  logic       svc_end,
  input  logic [1:0] bw_mode,
  input  logic       acc_done,
  input  logic       acc_write,
  input  logic       acc_last,
  output logic       stall_o,
  output logic       prio_elev_o
);

  localparam int SW = $clog2(STALL_LONG + 1);
  localparam int GW = $clog2(GRACE + 1);

  logic          active;
  logic [1:0]    mode_q;
  logic [GW-1:0] grace_cnt;
  logic [SW-1:0] stall_cnt;

  wire          past_grace = (grace_cnt == GW'(GRACE));
  wire          stall_req  = active && acc_done && acc_write && !acc_last
                             && past_grace && mode_q[1];
  wire [SW-1:0] stall_len  = mode_q[0] ? SW'(STALL_LONG) : SW'(STALL_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      mode_q    <= 2'b00;
      grace_cnt <= '0;
      stall_cnt <= '0;
    end else if (svc_start) begin
      active    <= 1'b1;
      mode_q    <= bw_mode;
      grace_cnt <= '0;
      stall_cnt <= '0;
    end else if (svc_end) begin
      active    <= 1'b0;
      grace_cnt <= '0;
      stall_cnt <= '0;
    end else if (active) begin
      if (stall_req)
        stall_cnt <= stall_len;
      else if (stall_cnt != '0)
        stall_cnt <= stall_cnt - 1'b1;
      if (acc_done && !past_grace)
        grace_cnt <= grace_cnt + 1'b1;
    end
  end

  assign stall_o     = (stall_cnt != '0);
  assign prio_elev_o = active && (mode_q == 2'b01) && past_grace;

  assert_stall_needs_stall_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> mode_q[1]);

  assert_elev_excludes_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prio_elev_o |-> !stall_o);

  assert_stall_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= SW'(STALL_LONG));

  assert_no_stall_in_grace_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!past_grace) |-> !stall_o);

  assert_last_write_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_start && active && acc_done && acc_last && !stall_o) |=> !stall_o);

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_start && $past(rst_n)) |=> $stable(mode_q));

  assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_end && !svc_start) |=> (!stall_o && !prio_elev_o));

  assert_read_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_start && active && acc_done && !acc_write && !stall_o) |=> !stall_o);

endmodule

// File: tb/dma_bw_throttle_tb.sv
module dma_bw_throttle_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_start = 1'b0, svc_end = 1'b0;
  logic [1:0] bw_mode = 2'b00;
  logic acc_done = 1'b0, acc_write = 1'b0, acc_last = 1'b0;
  logic stall_o, prio_elev_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit   m_active = 1'b0;
  logic [1:0] m_mode = 2'b00;
  int   m_cyc = 0;
  int   m_stall = 0;

  always #10 clk = ~clk;

  dma_bw_throttle u_dut (
    .clk(clk), .rst_n(rst_n), .svc_start(svc_start), .svc_end(svc_end),
    .bw_mode(bw_mode), .acc_done(acc_done), .acc_write(acc_write),
    .acc_last(acc_last), .stall_o(stall_o), .prio_elev_o(prio_elev_o));

  function automatic int stall_len(input logic [1:0] md);
    return (md == 2'b11) ? 8 : 4;
  endfunction

  function automatic bit exp_stall();
    return m_stall > 0;
  endfunction

  function automatic bit exp_prio();
    return m_active && (m_mode == 2'b01) && (m_cyc >= 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 1'b0; m_mode = 2'b00; m_cyc = 0; m_stall = 0;
    end else if (svc_start) begin
      m_active = 1'b1; m_mode = bw_mode; m_cyc = 0; m_stall = 0;
    end else if (svc_end) begin
      m_active = 1'b0; m_cyc = 0; m_stall = 0;
    end else if (m_active) begin
      if (m_stall > 0) m_stall--;
      if (acc_done) begin
        if (acc_write && !acc_last && m_cyc >= 2 && m_mode[1])
          m_stall = stall_len(m_mode);
        if (m_cyc < 2) m_cyc++;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk((m_mode == 2'b10) ? "R4 stall" : (m_mode == 2'b11) ? "R5 stall" : "R2 stall",
          stall_o, exp_stall());
      chk("R3 prio", prio_elev_o, exp_prio());
    end
  end

  task automatic idle();
    svc_start = 0; svc_end = 0; acc_done = 0; acc_write = 0; acc_last = 0;
  endtask

  task automatic start(input logic [1:0] md);
    @(negedge clk); idle(); svc_start = 1; bw_mode = md;
    @(negedge clk); idle();
  endtask

  task automatic access(input bit w, input bit l);
    @(negedge clk); idle(); acc_done = 1; acc_write = w; acc_last = l;
    @(negedge clk); idle();
  endtask

  task automatic measure_stall(input string tag, input int exp);
    int n = 0;
    while (stall_o && n < 20) begin n++; @(negedge clk); end
    chk(tag, n, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stall after reset", stall_o, 0);
    chk("R1 prio after reset", prio_elev_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stall idle", stall_o, 0);

    start(2'b00);
    for (int i = 0; i < 6; i++) access(i[0], 1'b0);
    chk("R2 no stall", stall_o, 0);
    chk("R2 no prio", prio_elev_o, 0);

    start(2'b10);
    access(0, 0); access(1, 0);
    chk("R6 no stall in grace", stall_o, 0);
    access(0, 0);
    chk("R10 read no stall", stall_o, 0);
    access(1, 0);
    chk("R4 stall raised", stall_o, 1);
    measure_stall("R4 stall length", 4);

    start(2'b11);
    access(0, 0); access(0, 0); access(1, 1);
    chk("R7 last write no stall", stall_o, 0);
    access(1, 0);
    measure_stall("R5 stall length", 8);

    start(2'b01);
    bw_mode = 2'b11;
    access(0, 0);
    chk("R6 prio held in grace", prio_elev_o, 0);
    access(1, 0);
    chk("R3 prio raised", prio_elev_o, 1);
    access(1, 0);
    chk("R8 held mode no stall", stall_o, 0);
    chk("R8 held mode prio", prio_elev_o, 1);

    start(2'b11);
    access(0, 0); access(0, 0); access(1, 0);
    chk("R9 stall before end", stall_o, 1);
    @(negedge clk); svc_end = 1; @(negedge clk); idle();
    chk("R9 stall cleared", stall_o, 0);
    start(2'b01);
    chk("R9 grace restarted", prio_elev_o, 0);
    access(1, 0); access(1, 0);
    chk("R9 prio after new grace", prio_elev_o, 1);

    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); idle();
      bw_mode = 2'($urandom);
      if (!m_active) begin
        if ($urandom_range(3) == 0) svc_start = 1;
      end else begin
        int r = $urandom_range(99);
        if (r < 2) svc_start = 1;
        else if (r < 5) svc_end = 1;
        else if (!stall_o && r < 65) begin
          acc_done = 1; acc_write = $urandom_range(1);
          acc_last = acc_write && ($urandom_range(6) == 0);
        end
      end
    end
    @(negedge clk); idle();
    @(negedge clk);
    finish_run();
  end
endmodule